// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycles of a 16-bit embedded controller whose low address bits and data share one set of pins. A requester presents an address, write data, per-byte lane enables, a direction, a flag for an 8-bit-wide region and a flag that suppresses the address phase on the shared bus. The block then plays out one bus cycle. The cycle opens with a short lead slot and then runs through four states, t1 to t4. Each of t1 to t4 lasts two clocks, so one clock is half a bus period. The separate address bus goes out during the lead slot, half a period before the address reaches the shared bus, and it stays valid to the end of t4.

The shared bus has an output enable for every pin. In t1 it carries the address and ALE is high. In t2 to t4 it carries write data, or it floats so that a read can come in. For an 8-bit region, the upper byte of the shared bus keeps carrying address through t2 to t4, and all data moves on the low byte. Read data is captured once per cycle and `done_o` marks the final clock. Between cycles, a bus hold request takes precedence over a new transfer. While the hold is granted, every bus output floats.

The requester keeps `req_i` high until it sees `done_o`. If it has no further transfer, it lowers `req_i` in that same clock. If `req_i` is still high at the end of t4, the next cycle follows with no idle clock.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is asserted, and when idle after reset: all `ad_oe_o` bits and `addr_oe_o` are 0, `ale_o` is 0, `rd_no` and `wr_no` are 1, `done_o` and `hold_ack_o` are 0, and `rdata_o` is 0.
- R2: A cycle starts only at a boundary, meaning idle or the last clock of t4, when `req_i` is high and `hold_req_i` is low. It lasts 9 clocks: 1 lead clock, then 2 clocks each for t1, t2, t3 and t4. `done_o` is high only in the 9th clock. A cycle may start in the clock right after `done_o`.
- R3: `addr_oe_o` is 1 from the lead clock through t4 and 0 otherwise, and `addr_o` shows the captured address. In the lead clock every `ad_oe_o` bit is 0.
- R4: When the address phase is enabled (`aph_off_i`=0), during both clocks of t1 AD[7:0] drive address[7:0], AD[15:8] drive address[15:8], and `ale_o` is 1. `ale_o` is 0 in every other clock.
- R5: In a 16-bit write, during t2 to t4 AD[7:0] drive wdata[7:0] when `be_i[0]`=1, and AD[15:8] drive wdata[15:8] when `be_i[1]`=1. A lane whose enable bit is 0 floats.
- R6: In an 8-bit region (`narrow_i`=1), AD[15:8] drive address[15:8] during t2 to t4. On a write, AD[7:0] carry wdata[15:8] when address bit 0 is 1 and wdata[7:0] when it is 0, and `be_i` is ignored.
- R7: `rd_no` is 0 during t2 and t3 of a read, and `wr_no` is 0 during t2 and t3 of a write; the two are never 0 together. On a read, during t2 to t4 every AD lane that does not carry address floats.
- R8: On a read, `ad_i` is captured at the end of the last clock of t3. A 16-bit read returns `ad_i` whole. An 8-bit read returns {8'h00, `ad_i[7:0]`}. `rdata_o` changes at no other time.
- R9: When the address phase is suppressed (`aph_off_i`=1), all AD pins float during t1 and `ale_o` stays 0. In an 8-bit region, AD[15:8] then carry address from t2 to t4.
- R10: The block grants hold (`hold_ack_o`=1 from the next clock) only at a boundary. Hold wins over a simultaneous request. While hold is granted, `addr_oe_o`, every `ad_oe_o` bit and `ale_oe_o` are 0, `ale_o` is 0, and `done_o` is 0. After `hold_req_i` drops, the block spends one idle clock before a pending cycle starts.
- R11: The request fields are captured when a cycle starts. Changing `addr_i`, `wdata_i`, `be_i`, `we_i`, `narrow_i` or `aph_off_i` during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one half bus period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, held until done |
| we_i | input | 1 | 1 = write, 0 = read |
| narrow_i | input | 1 | Target region is 8 bits wide |
| aph_off_i | input | 1 | Suppress address phase on shared bus |
| addr_i | input | AW (20) | Transfer address |
| wdata_i | input | DW (16) | Write data |
| be_i | input | DW/8 (2) | Byte-lane enables, bit k for AD lane k |
| hold_req_i | input | 1 | External bus hold request |
| hold_ack_o | output | 1 | Hold granted, bus floated |
| done_o | output | 1 | Last clock of the cycle |
| rdata_o | output | DW (16) | Captured read data |
| addr_o | output | AW (20) | Separate address bus value |
| addr_oe_o | output | 1 | Separate address bus drive enable |
| ad_o | output | DW (16) | Shared bus output value |
| ad_oe_o | output | DW (16) | Shared bus per-pin drive enables |
| ad_i | input | DW (16) | Shared bus input value |
| ale_o | output | 1 | Address latch enable |
| ale_oe_o | output | 1 | ALE drive enable (weak low when 0) |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
Two events can fall in the same clock: a hold request and a transfer request can both be pending at a cycle boundary, either at idle or in the last clock of t4. The bench raises both in the same clock at idle, and also raises hold partway through a running cycle while the requester keeps a follow-up ready. It checks that the running cycle finishes untouched, that `hold_ack_o` rises only in the clock after the boundary with every output floated, and that no lead clock appears until one idle clock after the hold is released.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  localparam int unsigned LANE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HOLD = 3'd1,
    PH_LEAD = 3'd2,
    PH_T1   = 3'd3,
    PH_T2   = 3'd4,
    PH_T3   = 3'd5,
    PH_T4   = 3'd6
  } phase_e;

  typedef struct packed {
    logic we;
    logic narrow;
    logic aoff;
  } xfer_ctl_t;

endpackage

// File: rtl/mbs_phase_ctrl.sv
module mbs_phase_ctrl
  import mbs_pkg::*;
#(
  parameter int unsigned SUB_CLKS = 2  // clocks per T-state, even
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   hold_req_i,
  output phase_e phase_o,
  output logic   t_end_o,
  output logic   last_o,
  output logic   start_o,
  output logic   hold_ack_o
);

  localparam int unsigned SW = (SUB_CLKS > 1) ? $clog2(SUB_CLKS) : 1;
  localparam logic [SW-1:0] SUB_LAST  = SW'(SUB_CLKS - 1);
  localparam logic [SW-1:0] LEAD_LAST = SW'(SUB_CLKS / 2 - 1);

  phase_e          ph_q, ph_d;
  logic [SW-1:0]   sub_q, sub_d;
  logic            boundary;

  assign t_end_o    = (sub_q == SUB_LAST);
  assign last_o     = (ph_q == PH_T4) && t_end_o;
  assign boundary   = (ph_q == PH_IDLE) || last_o;
  assign start_o    = boundary && req_i && !hold_req_i;
  assign hold_ack_o = (ph_q == PH_HOLD);
  assign phase_o    = ph_q;

  always_comb begin
    ph_d  = ph_q;
    sub_d = sub_q;
    unique case (ph_q)
      PH_IDLE: begin
        sub_d = '0;
        if (hold_req_i)  ph_d = PH_HOLD;
        else if (req_i)  ph_d = PH_LEAD;
      end
      PH_HOLD: begin
        sub_d = '0;
        if (!hold_req_i) ph_d = PH_IDLE;
      end
      PH_LEAD: begin
        if (sub_q == LEAD_LAST) begin
          ph_d  = PH_T1;
          sub_d = '0;
        end else begin
          sub_d = sub_q + SW'(1);
        end
      end
      default: begin
        if (sub_q != SUB_LAST) begin
          sub_d = sub_q + SW'(1);
        end else begin
          sub_d = '0;
          unique case (ph_q)
            PH_T1:   ph_d = PH_T2;
            PH_T2:   ph_d = PH_T3;
            PH_T3:   ph_d = PH_T4;
            // end of t4: same arbitration as idle, hold first
            default: ph_d = hold_req_i ? PH_HOLD : (req_i ? PH_LEAD : PH_IDLE);
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      sub_q <= '0;
    end else begin
      ph_q  <= ph_d;
      sub_q <= sub_d;
    end
  end

endmodule

// File: rtl/mbs_lane_drive.sv
module mbs_lane_drive
  import mbs_pkg::*;
#(
  parameter  int unsigned DW   = 16,
  localparam int unsigned NB   = DW / LANE_W,
  localparam int unsigned SELW = (NB > 1) ? $clog2(NB) : 1
) (
  input  phase_e           phase_i,
  input  xfer_ctl_t        ctl_i,
  input  logic [DW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NB-1:0]    be_i,
  output logic [DW-1:0]    ad_o,
  output logic [DW-1:0]    ad_oe_o,
  output logic             ale_o,
  output logic             ale_oe_o,
  output logic             addr_oe_o,
  output logic             rd_no,
  output logic             wr_no
);

  logic in_cyc, in_t1, in_data, in_strb;
  logic [LANE_W-1:0] nsel;

  assign in_cyc  = (phase_i == PH_LEAD) || (phase_i == PH_T1) || (phase_i == PH_T2) ||
                   (phase_i == PH_T3)   || (phase_i == PH_T4);
  assign in_t1   = (phase_i == PH_T1);
  assign in_data = (phase_i == PH_T2) || (phase_i == PH_T3) || (phase_i == PH_T4);
  assign in_strb = (phase_i == PH_T2) || (phase_i == PH_T3);

  assign addr_oe_o = in_cyc;
  assign ale_o     = in_t1 && !ctl_i.aoff;
  assign ale_oe_o  = (phase_i != PH_HOLD);
  assign rd_no     = !(in_strb && !ctl_i.we);
  assign wr_no     = !(in_strb && ctl_i.we);

  // 8-bit region: steer the addressed byte onto the low lane
  always_comb begin
    nsel = wdata_i[LANE_W-1:0];
    for (int b = 0; b < NB; b++) begin
      if (addr_i[SELW-1:0] == SELW'(b)) nsel = wdata_i[b*LANE_W +: LANE_W];
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic              oe;
    logic [LANE_W-1:0] val;
    always_comb begin
      oe  = 1'b0;
      val = addr_i[k*LANE_W +: LANE_W];
      if (in_t1) begin
        oe = !ctl_i.aoff;
      end else if (in_data) begin
        if (ctl_i.narrow) begin
          if (k == 0) begin
            oe  = ctl_i.we;
            val = nsel;
          end else begin
            oe  = 1'b1;  // upper lanes keep address
          end
        end else begin
          oe  = ctl_i.we && be_i[k];
          val = wdata_i[k*LANE_W +: LANE_W];
        end
      end
    end
    assign ad_oe_o[k*LANE_W +: LANE_W] = {LANE_W{oe}};
    assign ad_o[k*LANE_W +: LANE_W]    = oe ? val : '0;
  end

endmodule

// File: rtl/mbs_rd_capture.sv
module mbs_rd_capture
  import mbs_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          narrow_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (cap_i) begin
      rdata_o <= narrow_i ? {{(DW-LANE_W){1'b0}}, ad_i[LANE_W-1:0]} : ad_i;
    end
  end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter  int unsigned AW       = 20,
  parameter  int unsigned DW       = 16,
  parameter  int unsigned SUB_CLKS = 2,
  localparam int unsigned NB       = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          narrow_i,
  input  logic          aph_off_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] be_i,
  input  logic          hold_req_i,
  output logic          hold_ack_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe_o,
  output logic [DW-1:0] ad_o,
  output logic [DW-1:0] ad_oe_o,
  input  logic [DW-1:0] ad_i,
  output logic          ale_o,
  output logic          ale_oe_o,
  output logic          rd_no,
  output logic          wr_no
);

  phase_e        phase;
  logic          t_end, last, start;
  xfer_ctl_t     ctl_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] be_q;

  mbs_phase_ctrl #(.SUB_CLKS(SUB_CLKS)) i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .hold_req_i (hold_req_i),
    .phase_o    (phase),
    .t_end_o    (t_end),
    .last_o     (last),
    .start_o    (start),
    .hold_ack_o (hold_ack_o)
  );

  // request fields frozen for the whole cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start) begin
      ctl_q   <= '{we: we_i, narrow: narrow_i, aoff: aph_off_i};
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  mbs_lane_drive #(.DW(DW)) i_lanes (
    .phase_i   (phase),
    .ctl_i     (ctl_q),
    .addr_i    (addr_q[DW-1:0]),
    .wdata_i   (wdata_q),
    .be_i      (be_q),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .ale_oe_o  (ale_oe_o),
    .addr_oe_o (addr_oe_o),
    .rd_no     (rd_no),
    .wr_no     (wr_no)
  );

  mbs_rd_capture #(.DW(DW)) i_rdcap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    ((phase == PH_T3) && t_end && !ctl_q.we),
    .narrow_i (ctl_q.narrow),
    .ad_i     (ad_i),
    .rdata_o  (rdata_o)
  );

  assign addr_o = addr_q;
  assign done_o = last;

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          hold_ack_o,
  input logic          addr_oe_o,
  input logic [DW-1:0] ad_oe_o,
  input logic          ale_o,
  input logic          ale_oe_o,
  input logic          rd_no,
  input logic          wr_no,
  input logic [DW-1:0] rdata_o
);

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_lead_ad_float_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> (ad_oe_o == '0));

  assert_ale_in_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (addr_oe_o && ale_oe_o));

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> wr_no);

  assert_rdata_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(!rd_no));

  assert_hold_float_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_o |-> (!addr_oe_o && (ad_oe_o == '0) && !ale_oe_o && !ale_o && !done_o));

  assert_hold_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(done_o || !addr_oe_o));

endmodule

bind mux_bus_seq mbs_checker #(.DW(DW)) i_mbs_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .hold_ack_o (hold_ack_o),
  .addr_oe_o  (addr_oe_o),
  .ad_oe_o    (ad_oe_o),
  .ale_o      (ale_o),
  .ale_oe_o   (ale_oe_o),
  .rd_no      (rd_no),
  .wr_no      (wr_no),
  .rdata_o    (rdata_o)
);

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/1ps
module test_mux_bus_seq;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NB = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0, narrow_i = 1'b0, aph_off_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [NB-1:0] be_i = '0;
  logic          hold_req_i = 1'b0;
  logic          hold_ack_o, done_o, addr_oe_o, ale_o, ale_oe_o, rd_no, wr_no;
  logic [DW-1:0] rdata_o, ad_o, ad_oe_o;
  logic [DW-1:0] ad_i = '0;
  logic [AW-1:0] addr_o;

  int n_cmp = 0;
  int n_bad = 0;

  // current transfer, as the bench expects it
  logic [AW-1:0] t_addr;
  logic [DW-1:0] t_wd;
  logic [NB-1:0] t_be;
  logic          t_we, t_nar, t_aoff;
  logic [DW-1:0] exp_rd = '0;

  always #2 clk_i = ~clk_i;

  mux_bus_seq i_mux_bus_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .narrow_i, .aph_off_i, .addr_i, .wdata_i, .be_i,
    .hold_req_i, .hold_ack_o, .done_o, .rdata_o, .addr_o, .addr_oe_o, .ad_o, .ad_oe_o,
    .ad_i, .ale_o, .ale_oe_o, .rd_no, .wr_no
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h @%0t", tag, what, act, exp, $time);
    end
  endtask

  // p: 0 lead, 1-2 t1, 3-4 t2, 5-6 t3, 7-8 t4
  function automatic logic [15:0] exp_oe(int p);
    logic lo, hi;
    lo = 1'b0; hi = 1'b0;
    if (p == 1 || p == 2) begin
      lo = !t_aoff; hi = !t_aoff;
    end else if (p >= 3) begin
      if (t_nar) begin lo = t_we; hi = 1'b1; end
      else begin lo = t_we && t_be[0]; hi = t_we && t_be[1]; end
    end
    return {{8{hi}}, {8{lo}}};
  endfunction

  function automatic logic [15:0] exp_val(int p);
    if (p <= 2) return t_addr[15:0];
    if (t_nar) return {t_addr[15:8], t_addr[0] ? t_wd[15:8] : t_wd[7:0]};
    return t_wd;
  endfunction

  function automatic string ad_tag(int p);
    if (p == 0) return "R3";
    if (p <= 2) return t_aoff ? "R9" : "R4";
    if (t_nar)  return "R6";
    return t_we ? "R5" : "R7";
  endfunction

  task automatic check_phase(int p, logic [15:0] rd_old, logic [15:0] rd_new);
    logic [15:0] oe;
    oe = exp_oe(p);
    check("R3", "addr_oe", addr_oe_o, 1);
    check("R3", "addr", addr_o, t_addr);
    check(t_aoff ? "R9" : "R4", "ale", ale_o, (p == 1 || p == 2) && !t_aoff);
    check("R7", "rd_n", rd_no, !(!t_we && p >= 3 && p <= 6));
    check("R7", "wr_n", wr_no, !(t_we && p >= 3 && p <= 6));
    check("R2", "done", done_o, p == 8);
    check(ad_tag(p), "ad_oe", ad_oe_o, oe);
    check(ad_tag(p), "ad", ad_o & oe, exp_val(p) & oe);
    check("R8", "rdata", rdata_o, (p >= 7) ? rd_new : rd_old);
    check("R10", "hold_ack in cycle", hold_ack_o, 0);
  endtask

  // starts at a negedge where the next edge is a boundary
  task automatic do_xfer(logic [AW-1:0] a, logic [DW-1:0] wd, logic [NB-1:0] be,
                         logic we, logic nar, logic aoff, bit keep_req, int hold_at);
    logic [15:0] rd_val, rd_old, rd_new;
    t_addr = a; t_wd = wd; t_be = be; t_we = we; t_nar = nar; t_aoff = aoff;
    addr_i = a; wdata_i = wd; be_i = be; we_i = we; narrow_i = nar; aph_off_i = aoff;
    req_i = 1'b1;
    rd_val = 16'($urandom);
    rd_old = exp_rd;
    rd_new = we ? exp_rd : (nar ? {8'h00, rd_val[7:0]} : rd_val);
    ad_i = 16'($urandom);
    for (int p = 0; p < 9; p++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      check_phase(p, rd_old, rd_new);
      if (p == 4) check("R11", "addr held after input change", addr_o, t_addr);
      if (p == 2) begin  // R11: scramble inputs mid-cycle
        addr_i = AW'($urandom); wdata_i = 16'($urandom); be_i = 2'($urandom);
        we_i = 1'($urandom); narrow_i = 1'($urandom); aph_off_i = 1'($urandom);
      end
      if (p == hold_at) hold_req_i = 1'b1;
      if (p == 6) ad_i = rd_val;
      if (p == 7) ad_i = ~rd_val;
      if (p == 8) begin
        exp_rd = rd_new;
        if (!keep_req) req_i = 1'b0;
      end
    end
  endtask

  task automatic hold_run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      check("R10", "hold_ack", hold_ack_o, 1);
      check("R10", "addr_oe in hold", addr_oe_o, 0);
      check("R10", "ad_oe in hold", ad_oe_o, 0);
      check("R10", "ale_oe in hold", ale_oe_o, 0);
      check("R10", "ale in hold", ale_o, 0);
      check("R10", "done in hold", done_o, 0);
    end
    hold_req_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R10", "hold_ack released", hold_ack_o, 0);
    check("R10", "idle clock after release", addr_oe_o, 0);
  endtask

  task automatic check_idle(string tag);
    check(tag, "ad_oe", ad_oe_o, 0);
    check(tag, "addr_oe", addr_oe_o, 0);
    check(tag, "ale", ale_o, 0);
    check(tag, "rd_n", rd_no, 1);
    check(tag, "wr_n", wr_no, 1);
    check(tag, "done", done_o, 0);
    check(tag, "hold_ack", hold_ack_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk_i);
    check_idle("R1");
    check("R1", "rdata", rdata_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_idle("R1");
    check("R1", "rdata after reset", rdata_o, 0);

    // directed: wide writes with lane enables, back to back
    do_xfer(20'hA1234, 16'hBEEF, 2'b11, 1, 0, 0, 1, -1);
    do_xfer(20'h05678, 16'h1357, 2'b01, 1, 0, 0, 1, -1);
    do_xfer(20'h0ABCD, 16'h2468, 2'b10, 1, 0, 0, 0, -1);
    // narrow writes, odd and even address, be ignored
    do_xfer(20'h3C3C1, 16'hA55A, 2'b00, 1, 1, 0, 0, -1);
    do_xfer(20'h3C3C0, 16'hA55A, 2'b10, 1, 1, 0, 0, -1);
    // reads
    do_xfer(20'h11111, 16'h0000, 2'b11, 0, 0, 0, 0, -1);
    do_xfer(20'h22223, 16'h0000, 2'b11, 0, 1, 0, 0, -1);
    // address phase suppressed
    do_xfer(20'h4F00F, 16'h0000, 2'b11, 0, 1, 1, 0, -1);
    do_xfer(20'h4F00E, 16'h7E7E, 2'b01, 1, 1, 1, 0, -1);
    do_xfer(20'h6789A, 16'hC001, 2'b11, 1, 0, 1, 0, -1);
    repeat (2) @(negedge clk_i);
    check_idle("R2");

    // hold and request together at idle: hold wins
    hold_req_i = 1'b1;
    req_i = 1'b1;
    addr_i = 20'h0F0F0;
    hold_run(3);
    do_xfer(20'h0F0F0, 16'h9999, 2'b11, 0, 0, 0, 0, -1);

    // hold raised mid-cycle with follow-up pending: granted at end of t4
    do_xfer(20'h13579, 16'h8642, 2'b11, 1, 0, 0, 1, 4);
    hold_run(2);
    do_xfer(20'h2468A, 16'h0000, 2'b11, 0, 0, 0, 0, -1);

    // random mix
    for (int i = 0; i < 60; i++) begin
      bit keep;
      keep = (i == 59) ? 1'b0 : 1'($urandom);
      do_xfer(AW'($urandom), 16'($urandom), 2'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), keep, ($urandom % 4 == 0) ? 5 : -1);
      if (hold_req_i) begin
        hold_run(1 + $urandom % 3);
      end else if (!keep) begin
        repeat ($urandom % 3) @(negedge clk_i);
      end
    end
    repeat (2) @(negedge clk_i);
    check_idle("R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule